// File: doc/BRIEF.md
# Synchronous Serial Port Controller (Master/Slave)

This block exchanges characters over a four-wire synchronous serial link: serial clock, a data line in each direction and an active-low select. It runs either as the bus master, generating the serial clock from a programmable divider and framing transfers with select, or as a slave, shifting on a clock and select that another device supplies. Each character shifted out is matched by one character shifted in during the same clock pulses. A character is 8 or 9 bits long, sent most significant bit first. The clock is idle low, data is sampled on the rising edge and changed on the falling edge.

The host side is register-like. One character can wait in a holding register while the current one shifts, so a master keeps select low across any number of back-to-back characters. Received characters land in a two-entry buffer that the host drains one read at a time. A sticky flag records characters lost because that buffer was full. A debug-halt input, when enabled, freezes shifting and clock generation where they stand.

In master mode `dataOut` is the master-to-slave line and `dataIn` is the slave-to-master line. In slave mode the roles swap. The slave-side inputs `sckIn`, `ssnIn` and `dataIn` pass through two-flop synchronizers before edges are detected.

Top module: `spi_port`

## Requirements
- R1: After reset `txEmpty` is 1, `rxReady` and `rxOverflow` are 0, `ssnOut` is 1 and `sckOut` is 0.
- R2: `wideChar`=1 selects 9-bit characters and `wideChar`=0 selects 8-bit characters, in both directions. In 8-bit mode only `wrData[7:0]` is sent, and `rdData[8]` reads 0.
- R3: The holding register keeps one pending character, and `txEmpty` is 1 exactly when it is free. A write made while it is occupied is ignored. A character written while another is shifting is sent right after it.
- R4: In master mode `ssnOut` falls when a character is taken from the holding register. It stays low while the holding register is refilled before each character ends, and it rises at the end of a character when nothing is pending. `sckOut` is 0 whenever `ssnOut` is 1.
- R5: Each character sends its bits MSB first on `dataOut` and collects the same number of bits from `dataIn`. The clock idles low, the receiver samples on the rising edge and the transmitter changes its bit on the falling edge.
- R6: In master mode the high phase and the low phase of `sckOut` each last `clkDiv`+1 clock cycles, including the first low phase after select falls.
- R7: With `isMaster`=0 the block shifts only on `sckIn` edges while `ssnIn` is low. Clock edges with `ssnIn` high store nothing. `ssnOut` stays 1 and `sckOut` stays 0.
- R8: Received characters enter a two-entry buffer. `rdData` shows the oldest entry, a one-cycle `rdEn` removes it, and `rxReady` is 1 whenever the buffer holds an entry.
- R9: A character that completes while both buffer entries are full is dropped and sets `rxOverflow`. The flag stays set until `ovfClr` is pulsed.
- R10: With `dbgHaltEn`=1 and `dbgHalt`=1, `sckOut` and `ssnOut` hold their values and the transfer resumes unchanged when the halt ends.
- R11: With `dbgHaltEn`=0, `dbgHalt` has no effect and transfers complete normally.
- R12: A slave that finds its holding register empty at the start of a character transmits all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 selects master mode, 0 selects slave mode |
| wideChar | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit characters |
| clkDiv | input | DIV_W | Master clock divider; each half period is clkDiv+1 cycles |
| dbgHaltEn | input | 1 | Enables freezing on debug halt |
| dbgHalt | input | 1 | Debug halt request |
| wrEn | input | 1 | Writes wrData into the holding register |
| wrData | input | 9 | Character to transmit |
| txEmpty | output | 1 | Holding register is free |
| rdEn | input | 1 | Removes the oldest received character |
| rdData | output | 9 | Oldest received character |
| rxReady | output | 1 | Receive buffer is not empty |
| rxOverflow | output | 1 | Sticky flag for a dropped character |
| ovfClr | input | 1 | Clears rxOverflow |
| sckOut | output | 1 | Serial clock driven in master mode |
| ssnOut | output | 1 | Active-low select driven in master mode |
| sckIn | input | 1 | Serial clock received in slave mode |
| ssnIn | input | 1 | Active-low select received in slave mode |
| dataIn | input | 1 | Serial data in (slave-to-master line as master, master-to-slave line as slave) |
| dataOut | output | 1 | Serial data out (master-to-slave line as master, slave-to-master line as slave) |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, two synchronizer stages and a two-entry receive buffer. A buffer of only two entries means a three-character burst is enough to force the overflow drop and show that the flag is sticky. At run time the divider is set to 0, 3 and 7. This covers the fastest clock, where a new character is fetched on the same cycle the last bit ends, as well as slower clocks that leave time to test refills of the holding register and freezes in the middle of a character. Slave mode is driven by an external clock with eight-cycle half periods, which are long enough to pass through the synchronizers.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
  localparam int CHAR_W = 9;
  localparam int CNT_W = $clog2(CHAR_W);

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // move holding register (or zeros) into the shifter
    logic sample;  // capture the incoming bit
    logic shift;   // advance the shifter by one bit
    logic done;    // a character has completed
    logic rxBit;   // the incoming bit selected for this mode
  } spiStrobe_t;
endpackage

// File: rtl/spi_ctrl.sv
`timescale 1ns/1ps
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             wideChar,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             frozen,
  input  logic             holdFull,
  input  logic             sckIn,
  input  logic             ssnIn,
  input  logic             dataIn,
  output spiStrobe_t       strb,
  output logic             sckOut,
  output logic             ssnOut
);
  logic [SYNC_STAGES-1:0] sckSy, selSy, datSy;
  logic sckPrev, selPrev;
  logic sckS, selS, datS;
  logic running, sckR, ssnR;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt, lastBit;
  logic tick, mRise, mFall, mDone, mStart;
  logic sRise, sFall, sStart, sDone, lastNow;

  // input synchronizers
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sckSy <= '0; selSy <= '1; datSy <= '0;
        end else begin
          sckSy <= sckIn; selSy <= ssnIn; datSy <= dataIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sckSy <= '0; selSy <= '1; datSy <= '0;
        end else begin
          sckSy <= {sckSy[SYNC_STAGES-2:0], sckIn};
          selSy <= {selSy[SYNC_STAGES-2:0], ssnIn};
          datSy <= {datSy[SYNC_STAGES-2:0], dataIn};
        end
    end
  endgenerate

  assign sckS = sckSy[SYNC_STAGES-1];
  assign selS = selSy[SYNC_STAGES-1];
  assign datS = datSy[SYNC_STAGES-1];
  assign lastBit = wideChar ? CNT_W'(CHAR_W-1) : CNT_W'(CHAR_W-2);
  assign lastNow = (bitCnt == lastBit);

  // master timing
  assign tick   = running && !frozen && (divCnt == clkDiv);
  assign mRise  = isMaster && tick && !sckR;
  assign mFall  = isMaster && tick && sckR;
  assign mDone  = mFall && lastNow;
  assign mStart = isMaster && !frozen && !running && holdFull;

  // slave edge detection
  assign sRise  = !isMaster && !frozen && !selS && sckS && !sckPrev;
  assign sFall  = !isMaster && !frozen && !selS && !sckS && sckPrev;
  assign sStart = !isMaster && !frozen && !selS && selPrev;
  assign sDone  = sFall && lastNow;

  always_comb begin
    strb.sample = mRise | sRise;
    strb.shift  = mFall | sFall;
    strb.done   = mDone | sDone;
    strb.load   = mStart | (mDone & holdFull) | sStart | sDone;
    strb.rxBit  = isMaster ? dataIn : datS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      selPrev <= 1'b1;
      running <= 1'b0;
      sckR    <= 1'b0;
      ssnR    <= 1'b1;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      selPrev <= selS;
      if (isMaster) begin
        if (mStart) begin
          running <= 1'b1;
          ssnR    <= 1'b0;
          sckR    <= 1'b0;
          divCnt  <= '0;
          bitCnt  <= '0;
        end else if (running && !frozen) begin
          if (tick) begin
            divCnt <= '0;
            sckR   <= !sckR;
            if (sckR) begin
              if (lastNow) begin
                bitCnt <= '0;
                if (!holdFull) begin
                  running <= 1'b0;
                  ssnR    <= 1'b1;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      end else begin
        running <= 1'b0;
        ssnR    <= 1'b1;
        sckR    <= 1'b0;
        divCnt  <= '0;
        if (selS || sStart) bitCnt <= '0;
        else if (sFall) bitCnt <= lastNow ? '0 : bitCnt + 1'b1;
      end
    end
  end

  assign sckOut = sckR;
  assign ssnOut = ssnR;
endmodule

// File: rtl/spi_dp.sv
`timescale 1ns/1ps
module spi_dp
  import spi_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideChar,
  input  spiStrobe_t        strb,
  input  logic              wrEn,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              ovfClr,
  output logic              holdFull,
  output logic              dataOut,
  output logic [CHAR_W-1:0] rdData,
  output logic              rxReady,
  output logic              rxOverflow
);
  localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [CHAR_W-1:0] hold, shReg, rxChar, charMask;
  logic inBit;
  logic [CHAR_W-1:0] rxMem [RX_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic pop, accept;

  assign charMask = wideChar ? {CHAR_W{1'b1}} : {1'b0, {(CHAR_W-1){1'b1}}};
  assign rxChar   = {shReg[CHAR_W-2:0], inBit} & charMask;
  assign dataOut  = wideChar ? shReg[CHAR_W-1] : shReg[CHAR_W-2];
  assign pop      = rdEn && (count != '0);
  assign accept   = strb.done && (count != CNT_W'(RX_DEPTH));

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(RX_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hold     <= '0;
      holdFull <= 1'b0;
      shReg    <= '0;
      inBit    <= 1'b0;
    end else begin
      if (strb.load && holdFull) holdFull <= 1'b0;
      else if (wrEn && !holdFull) begin
        hold     <= wrData;
        holdFull <= 1'b1;
      end
      if (strb.load) shReg <= holdFull ? hold : '0;
      else if (strb.shift) shReg <= {shReg[CHAR_W-2:0], inBit};
      if (strb.sample) inBit <= strb.rxBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      count      <= '0;
      rxOverflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (accept && !pop) count <= count + 1'b1;
      else if (pop && !accept) count <= count - 1'b1;
      if (strb.done && !accept) rxOverflow <= 1'b1;
      else if (ovfClr) rxOverflow <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (accept) rxMem[wrPtr] <= rxChar;

  assign rdData  = rxMem[rdPtr];
  assign rxReady = (count != '0);
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RX_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             wideChar,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             dbgHaltEn,
  input  logic             dbgHalt,
  input  logic             wrEn,
  input  logic [8:0]       wrData,
  output logic             txEmpty,
  input  logic             rdEn,
  output logic [8:0]       rdData,
  output logic             rxReady,
  output logic             rxOverflow,
  input  logic             ovfClr,
  output logic             sckOut,
  output logic             ssnOut,
  input  logic             sckIn,
  input  logic             ssnIn,
  input  logic             dataIn,
  output logic             dataOut
);
  spiStrobe_t strb;
  logic holdFull;
  logic frozen;

  assign frozen  = dbgHaltEn & dbgHalt;
  assign txEmpty = !holdFull;

  spi_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .wideChar(wideChar),
    .clkDiv(clkDiv), .frozen(frozen), .holdFull(holdFull),
    .sckIn(sckIn), .ssnIn(ssnIn), .dataIn(dataIn),
    .strb(strb), .sckOut(sckOut), .ssnOut(ssnOut)
  );

  spi_dp #(.RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .wideChar(wideChar), .strb(strb),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .ovfClr(ovfClr),
    .holdFull(holdFull), .dataOut(dataOut), .rdData(rdData),
    .rxReady(rxReady), .rxOverflow(rxOverflow)
  );
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk (
  input logic clk,
  input logic rstN,
  input logic isMaster,
  input logic dbgHaltEn,
  input logic dbgHalt,
  input logic wrEn,
  input logic txEmpty,
  input logic ovfClr,
  input logic rxOverflow,
  input logic sckOut,
  input logic ssnOut
);
  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssnOut |-> !sckOut);

  // R3
  write_takes_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txEmpty) |=> !txEmpty);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflow && !ovfClr) |=> rxOverflow);

  // R10
  halt_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && dbgHaltEn && dbgHalt) |=> ($stable(sckOut) && $stable(ssnOut)));

  // R7
  slave_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && $past(!isMaster)) |-> (ssnOut && !sckOut));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .dbgHaltEn(dbgHaltEn),
  .dbgHalt(dbgHalt), .wrEn(wrEn), .txEmpty(txEmpty), .ovfClr(ovfClr),
  .rxOverflow(rxOverflow), .sckOut(sckOut), .ssnOut(ssnOut)
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  localparam int H = 8;  // slave-side half period in clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1, wideChar = 1'b0;
  logic [7:0] clkDiv = 8'd0;
  logic dbgHaltEn = 1'b0, dbgHalt = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, ovfClr = 1'b0;
  logic [8:0] wrData = '0;
  logic txEmpty, rxReady, rxOverflow, sckOut, ssnOut, dataOut;
  logic [8:0] rdData;
  logic sckIn = 1'b0, ssnIn = 1'b1, dataIn = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  spi_port uut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .wideChar(wideChar),
    .clkDiv(clkDiv), .dbgHaltEn(dbgHaltEn), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .wrData(wrData), .txEmpty(txEmpty), .rdEn(rdEn),
    .rdData(rdData), .rxReady(rxReady), .rxOverflow(rxOverflow),
    .ovfClr(ovfClr), .sckOut(sckOut), .ssnOut(ssnOut), .sckIn(sckIn),
    .ssnIn(ssnIn), .dataIn(dataIn), .dataOut(dataOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: remote slave in master mode plus receive-buffer model
  bit mstModel = 1'b0, pChk = 1'b1;
  logic [8:0] slvQ[$], gotQ[$], mq[$];
  logic [8:0] slvCur = '0, capBits = '0;
  bit mOvf = 1'b0;
  logic prevSck = 1'b0, prevSsn = 1'b1;
  int bitIdx = 0, hiCnt = 0, loCnt = 0, ssnFalls = 0, riseCnt = 0, len = 8;
  logic [8:0] msk;

  task automatic loadSlave();
    slvCur = (slvQ.size() != 0) ? slvQ.pop_front() : 9'd0;
    dataIn = slvCur[len-1];
  endtask

  always @(negedge clk) begin
    if (mstModel && rstN) begin
      len = wideChar ? 9 : 8;
      msk = wideChar ? 9'h1FF : 9'h0FF;
      if (prevSsn && !ssnOut) begin
        ssnFalls++; bitIdx = 0; loCnt = 1; loadSlave();
      end else if (!ssnOut && sckOut && !prevSck) begin
        riseCnt++;
        if (pChk) chk(loCnt == int'(clkDiv) + 1, "R6 low phase", loCnt, int'(clkDiv) + 1);
        capBits = {capBits[7:0], dataOut};
        hiCnt = 1;
      end else if (!sckOut && prevSck) begin
        if (pChk) chk(hiCnt == int'(clkDiv) + 1, "R6 high phase", hiCnt, int'(clkDiv) + 1);
        loCnt = 1;
        bitIdx++;
        if (bitIdx == len) begin
          gotQ.push_back(capBits & msk);
          if (mq.size() < 2) mq.push_back(slvCur & msk); else mOvf = 1'b1;
          bitIdx = 0;
          if (!ssnOut) loadSlave();
        end else begin
          dataIn = slvCur[len-1-bitIdx];
        end
      end else if (sckOut) hiCnt++;
      else loCnt++;
      chk(rxReady == (mq.size() != 0), "R8 rxReady", rxReady, mq.size() != 0);
      chk(rxOverflow == mOvf, "R9 rxOverflow", rxOverflow, mOvf);
      chk(!(ssnOut && sckOut), "R4 clock idle", sckOut, 0);
    end
    prevSck = sckOut;
    prevSsn = ssnOut;
  end

  task automatic wr(input logic [8:0] v);
    @(posedge clk); #2 wrData = v; wrEn = 1'b1;
    @(posedge clk); #2 wrEn = 1'b0;
  endtask

  task automatic popRx(input logic [8:0] exp, input string req);
    @(posedge clk); #2;
    chk(rxReady == 1'b1, req, rxReady, 1);
    chk(rdData == exp, req, rdData, exp);
    rdEn = 1'b1;
    @(posedge clk); #2 rdEn = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
  endtask

  task automatic clrOvf();
    @(posedge clk); #2 ovfClr = 1'b1;
    @(posedge clk); #2 ovfClr = 1'b0; mOvf = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(ssnOut && txEmpty));
    repeat (4) @(negedge clk);
  endtask

  // bench acts as master for slave-mode tests
  logic [8:0] mTxQ[$], sGotQ[$];
  task automatic slvXfer(input int n, input bit doRefill, input logic [8:0] refillV);
    logic [8:0] v, cap;
    int nb;
    nb = wideChar ? 9 : 8;
    @(posedge clk); #2 ssnIn = 1'b0; sckIn = 1'b0;
    repeat (H) @(posedge clk);
    if (doRefill) wr(refillV);
    for (int c = 0; c < n; c++) begin
      v = mTxQ.pop_front();
      cap = '0;
      for (int b = nb - 1; b >= 0; b--) begin
        #2 dataIn = v[b];
        repeat (H) @(posedge clk);
        #2 cap = {cap[7:0], dataOut}; sckIn = 1'b1;
        repeat (H) @(posedge clk);
        #2 sckIn = 1'b0;
      end
      sGotQ.push_back(cap & (wideChar ? 9'h1FF : 9'h0FF));
    end
    repeat (H) @(posedge clk);
    #2 ssnIn = 1'b1;
    repeat (2 * H) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    logic s0, n0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txEmpty == 1'b1, "R1 txEmpty", txEmpty, 1);
    chk(rxReady == 1'b0, "R1 rxReady", rxReady, 0);
    chk(rxOverflow == 1'b0, "R1 rxOverflow", rxOverflow, 0);
    chk(ssnOut == 1'b1, "R1 ssnOut", ssnOut, 1);
    chk(sckOut == 1'b0, "R1 sckOut", sckOut, 0);
    mstModel = 1'b1;

    // R5: single 8-bit exchange, divider 3
    clkDiv = 8'd3; wideChar = 1'b0;
    slvQ.push_back(9'h0A5);
    f0 = ssnFalls;
    wr(9'h13C);
    waitIdle();
    chk(gotQ.size() == 1 && gotQ[0] == 9'h03C, "R5 R2 sent 8-bit", gotQ.size() ? gotQ[0] : -1, 9'h03C);
    gotQ.delete();
    chk(ssnFalls == f0 + 1, "R4 one frame", ssnFalls - f0, 1);
    popRx(9'h0A5, "R5 R2 received");

    // R4 R9 R2: 9-bit burst of three at divider 0, buffer overflows
    clkDiv = 8'd0; wideChar = 1'b1;
    slvQ.push_back(9'h1C3); slvQ.push_back(9'h055); slvQ.push_back(9'h100);
    f0 = ssnFalls;
    wr(9'h1F0);
    wr(9'h0AB);
    do @(negedge clk); while (!txEmpty);
    wr(9'h16E);
    waitIdle();
    chk(ssnFalls == f0 + 1, "R4 select held", ssnFalls - f0, 1);
    chk(gotQ.size() == 3, "R3 R4 count", gotQ.size(), 3);
    if (gotQ.size() == 3) begin
      chk(gotQ[0] == 9'h1F0, "R2 nine bits 0", gotQ[0], 9'h1F0);
      chk(gotQ[1] == 9'h0AB, "R2 nine bits 1", gotQ[1], 9'h0AB);
      chk(gotQ[2] == 9'h16E, "R2 nine bits 2", gotQ[2], 9'h16E);
    end
    gotQ.delete();
    chk(rxOverflow == 1'b1, "R9 overflow set", rxOverflow, 1);
    repeat (5) @(negedge clk);
    chk(rxOverflow == 1'b1, "R9 sticky", rxOverflow, 1);
    clrOvf();
    @(negedge clk);
    chk(rxOverflow == 1'b0, "R9 cleared", rxOverflow, 0);
    popRx(9'h1C3, "R8 oldest first");
    popRx(9'h055, "R8 second");
    @(negedge clk);
    chk(rxReady == 1'b0, "R8 drained", rxReady, 0);

    // R3: write while holding register is occupied is ignored
    clkDiv = 8'd7; wideChar = 1'b0;
    f0 = ssnFalls;
    wr(9'h011);
    wr(9'h022);
    wr(9'h033);
    @(negedge clk);
    chk(txEmpty == 1'b0, "R3 holding occupied", txEmpty, 0);
    waitIdle();
    chk(gotQ.size() == 2, "R3 third write dropped", gotQ.size(), 2);
    if (gotQ.size() == 2) begin
      chk(gotQ[0] == 9'h011, "R3 first", gotQ[0], 9'h011);
      chk(gotQ[1] == 9'h022, "R3 second", gotQ[1], 9'h022);
    end
    gotQ.delete();
    chk(ssnFalls == f0 + 1, "R4 refill keeps select", ssnFalls - f0, 1);
    popRx(9'h000, "R8 drain a");
    popRx(9'h000, "R8 drain b");

    // R10: freeze in mid character
    clkDiv = 8'd3;
    slvQ.push_back(9'h03D);
    wr(9'h096);
    repeat (10) @(posedge clk);
    pChk = 1'b0;
    #2 dbgHaltEn = 1'b1; dbgHalt = 1'b1;
    @(negedge clk);
    s0 = sckOut; n0 = ssnOut;
    chk(n0 == 1'b0, "R10 mid transfer", n0, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(sckOut == s0 && ssnOut == n0, "R10 frozen", {sckOut, ssnOut}, {s0, n0});
    end
    @(posedge clk); #2 dbgHalt = 1'b0; dbgHaltEn = 1'b0;
    waitIdle();
    pChk = 1'b1;
    chk(gotQ.size() == 1 && gotQ[0] == 9'h096, "R10 resumes", gotQ.size() ? gotQ[0] : -1, 9'h096);
    gotQ.delete();
    popRx(9'h03D, "R10 received");

    // R11: halt request with enable clear has no effect
    @(posedge clk); #2 dbgHalt = 1'b1;
    f0 = riseCnt;
    slvQ.push_back(9'h0C9);
    wr(9'h06E);
    waitIdle();
    chk(riseCnt == f0 + 8, "R11 clock ran", riseCnt - f0, 8);
    chk(gotQ.size() == 1 && gotQ[0] == 9'h06E, "R11 data", gotQ.size() ? gotQ[0] : -1, 9'h06E);
    gotQ.delete();
    popRx(9'h0C9, "R11 received");
    @(posedge clk); #2 dbgHalt = 1'b0;

    // slave mode, 9-bit, with refill during first character
    mstModel = 1'b0;
    @(posedge clk); #2 isMaster = 1'b0; wideChar = 1'b1;
    wr(9'h1A6);
    mTxQ.push_back(9'h0F3); mTxQ.push_back(9'h12D);
    slvXfer(2, 1'b1, 9'h071);
    chk(sGotQ.size() == 2, "R7 slave count", sGotQ.size(), 2);
    if (sGotQ.size() == 2) begin
      chk(sGotQ[0] == 9'h1A6, "R7 R5 slave sent 0", sGotQ[0], 9'h1A6);
      chk(sGotQ[1] == 9'h071, "R3 slave refill", sGotQ[1], 9'h071);
    end
    sGotQ.delete();
    popRx(9'h0F3, "R7 slave rx 0");
    popRx(9'h12D, "R7 slave rx 1");
    chk(ssnOut == 1'b1 && sckOut == 1'b0, "R7 master lines idle", {ssnOut, sckOut}, 2);

    // R7: clock edges with select high are ignored
    @(posedge clk); #2 wideChar = 1'b0; dataIn = 1'b1;
    for (int i = 0; i < 9; i++) begin
      repeat (H) @(posedge clk); #2 sckIn = 1'b1;
      repeat (H) @(posedge clk); #2 sckIn = 1'b0;
    end
    repeat (2 * H) @(negedge clk);
    chk(rxReady == 1'b0, "R7 deselected ignored", rxReady, 0);

    // R12: empty holding register sends zeros; R2 8-bit receive upper bit zero
    mTxQ.push_back(9'h05A);
    slvXfer(1, 1'b0, 9'h000);
    chk(sGotQ.size() == 1 && sGotQ[0] == 9'h000, "R12 zeros", sGotQ.size() ? sGotQ[0] : -1, 0);
    sGotQ.delete();
    popRx(9'h05A, "R7 R2 slave rx 8-bit");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule